// File: doc/BRIEF.md
# Modal Button Command Decoder

This block turns four clean, single-cycle key pulses into single-cycle commands for a small stack calculator. Two action keys (A and B) carry six operations between them, because a separate mode key steps an internal mode register through three levels. The mode chooses which operation an action key means. A fourth key, clear, always issues a reset command. The command outputs form a vector with at most one bit set, and the current mode is driven out so that a display can show it.

A key pulse is sampled on a rising clock edge. With the default registered output, the command and the new mode are both visible for exactly one cycle after that edge. Debouncing and synchronisation happen upstream. Running the commands is left to the stack datapath that consumes them.

Top module: `modal_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released with no key pressed, `mode_o` is 0 and `cmd_o` is all zeros.
- R2: In mode 0, key A issues push (`cmd_o` bit 0) and key B issues pop (bit 1). The mode stays 0, and it holds its value on every cycle with no key.
- R3: A lone mode-key pulse issues no command and steps the mode 0→1→2→0. The value 3 never appears on `mode_o`.
- R4: In mode 1, key A issues add (bit 2) and key B issues subtract (bit 3).
- R5: In mode 2, key A issues negate (bit 4) and key B issues swap of the top two entries (bit 5).
- R6: The clear key issues reset (bit 6) in any mode, forces the mode to 0, and overrides every other key pressed in the same cycle.
- R7: After an operation is issued from mode 1 or mode 2, the mode returns to 0 (parameter `RETURN_TO_BASE`=1).
- R8: When keys are pressed together without clear, key A wins over key B, and any action key wins over the mode key. A mode key that loses has no effect on the mode.
- R9: At most one bit of `cmd_o` is set in any cycle. A single-cycle key pulse gives a command lasting exactly one cycle.
- R10: With `OUT_REG`=1, the command and the new mode both appear in the cycle that follows the clock edge on which the key was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_a_i | input | 1 | Action key A pulse |
| key_b_i | input | 1 | Action key B pulse |
| key_mode_i | input | 1 | Mode step key pulse |
| key_clr_i | input | 1 | Clear key pulse |
| cmd_o | output | 7 | Command pulses: 0 push, 1 pop, 2 add, 3 sub, 4 negate, 5 swap, 6 reset |
| mode_o | output | 2 | Current mode (0, 1 or 2) |

## Verification
The bench builds the decoder with its default parameters: registered outputs and a return to mode 0 after each operation. With these settings every command falls exactly one cycle after its key. This lets a queue of expected command and mode pairs be compared cycle by cycle. The same settings bring within reach the return from modes 1 and 2, the full wrap of the mode sequence, and the priority among keys pressed together in every mode.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        MODE_BASE  = 2'd0,
        MODE_ARITH = 2'd1,
        MODE_EXT   = 2'd2
    } mode_e;

    localparam int MODE_W  = 2;
    localparam int CMD_W   = 7;

    localparam int CMD_PUSH  = 0;
    localparam int CMD_POP   = 1;
    localparam int CMD_ADD   = 2;
    localparam int CMD_SUB   = 3;
    localparam int CMD_NEG   = 4;
    localparam int CMD_SWAP  = 5;
    localparam int CMD_RESET = 6;

    // Winning key after priority resolution; at most one field set.
    typedef struct packed {
        logic clr;
        logic act_a;
        logic act_b;
        logic adv;
    } key_sel_t;

    function automatic mode_e mode_step(mode_e m);
        mode_e r;
        case (m)
            MODE_BASE:  r = MODE_ARITH;
            MODE_ARITH: r = MODE_EXT;
            default:    r = MODE_BASE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbd_key_arbiter.sv
module mbd_key_arbiter
    import mbd_pkg::*;
(
    input  logic     key_a_i,
    input  logic     key_b_i,
    input  logic     key_mode_i,
    input  logic     key_clr_i,
    output key_sel_t sel_o
);

    // Priority: clear, then action A, then action B, then mode step.
    always_comb begin
        sel_o = '0;
        if (key_clr_i) begin
            sel_o.clr = 1'b1;
        end else if (key_a_i) begin
            sel_o.act_a = 1'b1;
        end else if (key_b_i) begin
            sel_o.act_b = 1'b1;
        end else if (key_mode_i) begin
            sel_o.adv = 1'b1;
        end
    end

endmodule

// File: rtl/mbd_mode_fsm.sv
module mbd_mode_fsm
    import mbd_pkg::*;
#(
    parameter bit RETURN_TO_BASE = 1'b1
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  key_sel_t sel_i,
    output mode_e    mode_o
);

    typedef struct packed {
        mode_e mode;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_i.clr) begin
            st_d.mode = MODE_BASE;
        end else if (sel_i.act_a || sel_i.act_b) begin
            if (RETURN_TO_BASE) begin
                st_d.mode = MODE_BASE;
            end
        end else if (sel_i.adv) begin
            st_d.mode = mode_step(st_q.mode);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_BASE};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/mbd_cmd_map.sv
module mbd_cmd_map
    import mbd_pkg::*;
(
    input  key_sel_t         sel_i,
    input  mode_e            mode_i,
    output logic [CMD_W-1:0] cmd_o
);

    always_comb begin
        cmd_o = '0;
        if (sel_i.clr) begin
            cmd_o[CMD_RESET] = 1'b1;
        end else if (sel_i.act_a) begin
            case (mode_i)
                MODE_BASE:  cmd_o[CMD_PUSH] = 1'b1;
                MODE_ARITH: cmd_o[CMD_ADD]  = 1'b1;
                default:    cmd_o[CMD_NEG]  = 1'b1;
            endcase
        end else if (sel_i.act_b) begin
            case (mode_i)
                MODE_BASE:  cmd_o[CMD_POP]  = 1'b1;
                MODE_ARITH: cmd_o[CMD_SUB]  = 1'b1;
                default:    cmd_o[CMD_SWAP] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/mbd_out_stage.sv
module mbd_out_stage #(
    parameter int  WIDTH   = 7,
    parameter bit  OUT_REG = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] cmd_i,
    output logic [WIDTH-1:0] cmd_o
);

    generate
        if (OUT_REG) begin : g_reg
            logic [WIDTH-1:0] cmd_d, cmd_q;

            always_comb begin
                cmd_d = cmd_i;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cmd_q <= '0;
                end else begin
                    cmd_q <= cmd_d;
                end
            end

            assign cmd_o = cmd_q;
        end else begin : g_pass
            assign cmd_o = cmd_i;
        end
    endgenerate

endmodule

// File: rtl/modal_cmd_decoder.sv
module modal_cmd_decoder
    import mbd_pkg::*;
#(
    parameter bit OUT_REG        = 1'b1,
    parameter bit RETURN_TO_BASE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_a_i,
    input  logic              key_b_i,
    input  logic              key_mode_i,
    input  logic              key_clr_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [MODE_W-1:0] mode_o
);

    key_sel_t         sel;
    mode_e            mode_cur;
    logic [CMD_W-1:0] cmd_raw;

    mbd_key_arbiter u_arb (
        .key_a_i    (key_a_i),
        .key_b_i    (key_b_i),
        .key_mode_i (key_mode_i),
        .key_clr_i  (key_clr_i),
        .sel_o      (sel)
    );

    mbd_mode_fsm #(
        .RETURN_TO_BASE (RETURN_TO_BASE)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel),
        .mode_o (mode_cur)
    );

    mbd_cmd_map u_map (
        .sel_i  (sel),
        .mode_i (mode_cur),
        .cmd_o  (cmd_raw)
    );

    mbd_out_stage #(
        .WIDTH   (CMD_W),
        .OUT_REG (OUT_REG)
    ) u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (cmd_raw),
        .cmd_o  (cmd_o)
    );

    assign mode_o = mode_cur;

endmodule

// File: rtl/modal_cmd_decoder_chk.sv
module modal_cmd_decoder_chk #(
    parameter bit OUT_REG        = 1'b1,
    parameter bit RETURN_TO_BASE = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       key_a_i,
    input logic       key_b_i,
    input logic       key_mode_i,
    input logic       key_clr_i,
    input logic [6:0] cmd_o,
    input logic [1:0] mode_o
);

    logic no_key;
    assign no_key = !key_a_i && !key_b_i && !key_mode_i && !key_clr_i;

    p_cmd_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cmd_o));

    p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o != 2'd3);

    p_clr_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_clr_i |=> mode_o == 2'd0);

    p_mode_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_mode_i && !key_a_i && !key_b_i && !key_clr_i) |=>
        mode_o == (($past(mode_o) == 2'd2) ? 2'd0 : $past(mode_o) + 2'd1));

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_key |=> $stable(mode_o));

    generate
        if (RETURN_TO_BASE) begin : g_ret
            p_return_base_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ((key_a_i || key_b_i) && !key_clr_i) |=> mode_o == 2'd0);
        end
        if (OUT_REG) begin : g_reg
            p_clr_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                key_clr_i |=> cmd_o == 7'b100_0000);
            p_idle_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                no_key |=> cmd_o == 7'd0);
        end else begin : g_comb
            p_clr_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                key_clr_i |-> cmd_o == 7'b100_0000);
            p_idle_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                no_key |-> cmd_o == 7'd0);
        end
    endgenerate

endmodule

bind modal_cmd_decoder modal_cmd_decoder_chk #(
    .OUT_REG        (OUT_REG),
    .RETURN_TO_BASE (RETURN_TO_BASE)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_a_i    (key_a_i),
    .key_b_i    (key_b_i),
    .key_mode_i (key_mode_i),
    .key_clr_i  (key_clr_i),
    .cmd_o      (cmd_o),
    .mode_o     (mode_o)
);

// File: tb/modal_cmd_decoder_test.sv
module modal_cmd_decoder_test;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       key_a_i = 1'b0;
    logic       key_b_i = 1'b0;
    logic       key_mode_i = 1'b0;
    logic       key_clr_i = 1'b0;
    logic [6:0] cmd_o;
    logic [1:0] mode_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] cmd;
        logic [1:0] mode;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   m_model = 0;

    always #4 clk_i = ~clk_i;

    modal_cmd_decoder uut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .key_a_i    (key_a_i),
        .key_b_i    (key_b_i),
        .key_mode_i (key_mode_i),
        .key_clr_i  (key_clr_i),
        .cmd_o      (cmd_o),
        .mode_o     (mode_o)
    );

    // Driver: one step per cycle, expected result queued for the monitor.
    task automatic step(input bit a, input bit b, input bit md, input bit c, input string tag);
        exp_t e;
        @(negedge clk_i);
        key_a_i = a; key_b_i = b; key_mode_i = md; key_clr_i = c;
        e.cmd = 7'd0;
        if (c) begin
            e.cmd = 7'b100_0000;
            m_model = 0;
        end else if (a) begin
            e.cmd = (m_model == 0) ? 7'b000_0001 : (m_model == 1) ? 7'b000_0100 : 7'b001_0000;
            m_model = 0;
        end else if (b) begin
            e.cmd = (m_model == 0) ? 7'b000_0010 : (m_model == 1) ? 7'b000_1000 : 7'b010_0000;
            m_model = 0;
        end else if (md) begin
            m_model = (m_model + 1) % 3;
        end
        e.mode = m_model[1:0];
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares after each edge.
    initial begin
        forever begin
            @(posedge clk_i);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cmd_o !== e.cmd || mode_o !== e.mode) begin
                    failures++;
                    $display("FAIL %s: cmd=%b mode=%0d expected cmd=%b mode=%0d",
                             e.tag, cmd_o, mode_o, e.cmd, e.mode);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        checks++;
        if (cmd_o !== 7'd0 || mode_o !== 2'd0) begin
            failures++;
            $display("FAIL R1 in reset: cmd=%b mode=%0d expected cmd=0 mode=0", cmd_o, mode_o);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);
        checks++;
        if (cmd_o !== 7'd0 || mode_o !== 2'd0) begin
            failures++;
            $display("FAIL R1 after release: cmd=%b mode=%0d expected cmd=0 mode=0", cmd_o, mode_o);
        end

        step(1, 0, 0, 0, "R2 push");
        step(0, 0, 0, 0, "R9 push lasts one cycle");
        step(0, 1, 0, 0, "R2 pop");
        step(0, 0, 0, 0, "R2 idle hold");
        step(0, 0, 1, 0, "R3 step to 1");
        step(1, 0, 0, 0, "R4 add R7 return");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 0, 0, "R2 idle hold in mode 1");
        step(0, 1, 0, 0, "R4 sub R7 return");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 1, 0, "R3 step to 2");
        step(1, 0, 0, 0, "R5 negate R7 return");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 1, 0, "R3 step to 2");
        step(0, 1, 0, 0, "R5 swap R7 return");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 1, 0, "R3 step to 2");
        step(0, 0, 1, 0, "R3 wrap to 0");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 0, 1, "R6 clear in mode 1");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 1, 0, "R3 step to 2");
        step(1, 1, 1, 1, "R6 clear overrides all keys");
        step(1, 1, 0, 0, "R8 A over B in mode 0");
        step(0, 0, 1, 0, "R3 step to 1");
        step(1, 0, 1, 0, "R8 A over mode key in mode 1");
        step(0, 0, 1, 0, "R3 step to 1");
        step(0, 0, 1, 0, "R3 step to 2");
        step(0, 1, 1, 0, "R8 B over mode key in mode 2");
        step(0, 0, 0, 1, "R10 clear latency");
        step(0, 0, 0, 0, "R9 no residue");
        step(0, 0, 0, 0, "R9 idle");
        while (exp_q.size() > 0) @(negedge clk_i);
        @(negedge clk_i);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule